// File: doc/BRIEF.md
# Buffered Serial Port Register Core

This block is the register-side core of a serial port. A processor reaches it through a simple byte-wide register bus with separate write and read strobes. The block keeps the mode, control, port and FIFO-control registers, sticky status flags that are cleared by writing zero, and a 16-deep receive FIFO with a selectable fill threshold. It also drives a receive interrupt and a transmit interrupt. Bytes written for transmission leave on a valid/ready byte stream. Received bytes arrive on a second valid/ready stream, and line-break events arrive on a one-cycle pulse input.

Back-pressure on the streams works as follows. The receive stream's `rx_ready` equals the receive-enable control bit. A byte is transferred in any cycle where `rx_valid` and `rx_ready` are both high. A transferred byte that finds the FIFO full is discarded. On the transmit side there is a single holding stage. `tx_valid` stays high and `tx_data` stays stable until a cycle where `tx_ready` is high. A transmit-register write that arrives while a byte is still pending and not taken is lost. Bit timing, baud generation and line-error detection belong to neighbouring logic.

Register offsets on `bus_addr`: 0x00 mode, 0x08 control, 0x0C transmit data, 0x10 status, 0x14 receive data, 0x18 FIFO control, 0x1C receive count, 0x20 port. Control bits: 7 transmit-interrupt enable, 6 receive-interrupt enable, 5 transmit enable, 4 receive enable.

Top module: `sfr_serial_core`

## Requirements
- R1: After reset, control reads 0x20, status reads 0x60, receive count reads 0, both interrupts are low, `tx_valid` is low and `rx_ready` is low.
- R2: Readback of a written value is masked: mode with 0x7B, control with 0xFA, port with 0xF3. FIFO control reads back its bits 7:6 with all other bits zero. A read of any offset outside the map returns 0.
- R3: The receive FIFO returns up to 16 bytes in arrival order. A byte transferred while 16 are held is dropped and the count stays at 16.
- R4: `rx_ready` equals control bit 4. With that bit at 0, `rx_valid` has no effect on the receive count.
- R5: Status bit 1 (data-ready flag) is set when a stored byte brings the count to at least the trigger level. FIFO control bits 7:6 select the trigger level: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14.
- R6: A read of receive data returns the oldest byte and removes it. If the count after the removal is below the trigger level, status bit 1 clears. A read while the FIFO is empty returns 0 and changes nothing. A read and a transfer in the same cycle leave the count unchanged.
- R7: `irq_rx` rises when a stored byte reaches the trigger level while control bit 6 is 1. It falls on a control write with bit 6 at 0, or on a status write with bit 1 or bit 0 at 0.
- R8: `irq_tx` follows bit 7 of the most recent control write.
- R9: A write to transmit data presents the byte on `tx_data` with `tx_valid` high until `tx_ready` is seen, and clears status bit 5 (transmit-empty). A write made while a byte is still pending and not taken is discarded.
- R10: Status layout: bit 6 transmit-end, bit 5 transmit-empty, bit 4 break, bit 1 data-ready, all other bits zero. Writing 0 to a flag bit clears it. Writing 1 leaves it unchanged.
- R11: A control write with bit 5 at 0 sets transmit-end. A status read made while control bit 5 is 1 returns the current flags and then sets transmit-end and transmit-empty.
- R12: A pulse on `rx_break` sets status bit 4.
- R13: Writing FIFO control with bit 1 at 1 empties the receive FIFO. A byte transferred in that same cycle is discarded.
- R14: When a byte storage that reaches the trigger level and a status write clearing bit 1 fall in the same cycle, bit 1 ends up set and `irq_rx` ends up high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; receive-data and status reads have side effects |
| bus_rdata | output | 8 | Read data, valid in the cycle of `bus_rd` |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Receive stream accepts bytes |
| rx_break | input | 1 | One-cycle line-break event |
| tx_valid | output | 1 | Transmit byte pending |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmit consumer takes the byte |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |

## Verification
Two functions can act on the data-ready flag and the receive interrupt in one cycle: a byte stored by the receive stream, and a register access that clears or drains, namely a status write of zero, a receive-data read or a flush. The bench drives a stream transfer in the same clock as each of these bus accesses. It then judges the outcome at the ports: the stored byte's set must win over the status clear, a read plus a transfer must keep the count, and a flush must discard the transfer. A sweep over all four trigger codes fills and drains the FIFO and compares the flag after every step against the threshold computed in the bench.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam logic [7:0] OFS_MODE = 8'h00;
  localparam logic [7:0] OFS_CTRL = 8'h08;
  localparam logic [7:0] OFS_TXD  = 8'h0C;
  localparam logic [7:0] OFS_STAT = 8'h10;
  localparam logic [7:0] OFS_RXD  = 8'h14;
  localparam logic [7:0] OFS_FCTL = 8'h18;
  localparam logic [7:0] OFS_RCNT = 8'h1C;
  localparam logic [7:0] OFS_PORT = 8'h20;

  localparam int CB_TXIE = 7;
  localparam int CB_RXIE = 6;
  localparam int CB_TXEN = 5;
  localparam int CB_RXEN = 4;

  localparam int FB_TEND = 6;
  localparam int FB_TDE  = 5;
  localparam int FB_BRK  = 4;
  localparam int FB_RDF  = 1;
  localparam int FB_DR   = 0;

  localparam logic [7:0] MASK_MODE = 8'h7B;
  localparam logic [7:0] MASK_CTRL = 8'hFA;
  localparam logic [7:0] MASK_PORT = 8'hF3;
  localparam logic [7:0] CTRL_RESET = 8'h20;

  function automatic int trig_of(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/sfr_rx_fifo.sv
module sfr_rx_fifo #(
  parameter int DW = 8,
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic          flush,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [DW-1:0] head_data,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  assign push_ok   = push && !flush && (count < CW'(DEPTH));
  assign pop_ok    = pop && !flush && (count != '0);
  assign head_data = mem[rd_ptr];

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wrap_inc(wr_ptr);
      if (pop_ok)  rd_ptr <= wrap_inc(rd_ptr);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !flush && count == CW'(DEPTH)) |=> count == CW'(DEPTH));

  assert_flush_empty_R13: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count == '0);
endmodule

// File: rtl/sfr_tx_hold.sv
module sfr_tx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          tx_ready
);
  logic slot_free;
  assign slot_free = !tx_valid || tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (load && slot_free) begin
      tx_valid <= 1'b1;
      tx_data  <= load_data;
    end else if (tx_ready) begin
      tx_valid <= 1'b0;
    end
  end

  assert_tx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  assert_tx_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !tx_valid) |=> tx_valid);
endmodule

// File: rtl/sfr_serial_core.sv
module sfr_serial_core
  import sfr_pkg::*;
#(
  parameter int AW = 8,
  parameter int RX_DEPTH = 16,
  localparam int DW = 8,
  localparam int CW = $clog2(RX_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          rx_ready,
  input  logic          rx_break,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          tx_ready,
  output logic          irq_rx,
  output logic          irq_tx
);
  logic [DW-1:0] mode_q, ctrl_q, port_q;
  logic [1:0]    trig_code_q;
  logic          tend_q, tde_q, brk_q, rdf_q;
  logic          irq_rx_q, irq_tx_q;

  logic wr_mode, wr_ctrl, wr_txd, wr_stat, wr_fctl, wr_port;
  logic rd_stat, rd_rxd;
  logic push, pop, flush;
  logic fifo_push_ok, fifo_pop_ok;
  logic [DW-1:0] fifo_head;
  logic [CW-1:0] fifo_cnt, cnt_after, trig_lvl;
  logic reach_trig, drop_trig;

  assign wr_mode = bus_wr && (bus_addr == AW'(OFS_MODE));
  assign wr_ctrl = bus_wr && (bus_addr == AW'(OFS_CTRL));
  assign wr_txd  = bus_wr && (bus_addr == AW'(OFS_TXD));
  assign wr_stat = bus_wr && (bus_addr == AW'(OFS_STAT));
  assign wr_fctl = bus_wr && (bus_addr == AW'(OFS_FCTL));
  assign wr_port = bus_wr && (bus_addr == AW'(OFS_PORT));
  assign rd_stat = bus_rd && (bus_addr == AW'(OFS_STAT));
  assign rd_rxd  = bus_rd && (bus_addr == AW'(OFS_RXD));

  assign rx_ready = ctrl_q[CB_RXEN];
  assign push     = rx_valid && rx_ready;
  assign pop      = rd_rxd;
  assign flush    = wr_fctl && bus_wdata[1];

  sfr_rx_fifo #(.DW(DW), .DEPTH(RX_DEPTH)) rx_fifo_i (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_data(rx_data),
    .pop(pop), .flush(flush),
    .push_ok(fifo_push_ok), .pop_ok(fifo_pop_ok),
    .head_data(fifo_head), .count(fifo_cnt)
  );

  sfr_tx_hold #(.DW(DW)) tx_hold_i (
    .clk(clk), .rst_n(rst_n),
    .load(wr_txd), .load_data(bus_wdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
  );

  assign trig_lvl   = CW'(trig_of(trig_code_q));
  assign cnt_after  = fifo_cnt + CW'(fifo_push_ok) - CW'(fifo_pop_ok);
  assign reach_trig = fifo_push_ok && (cnt_after >= trig_lvl);
  assign drop_trig  = fifo_pop_ok && (cnt_after < trig_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= '0;
      ctrl_q      <= CTRL_RESET;
      port_q      <= '0;
      trig_code_q <= 2'd0;
    end else begin
      if (wr_mode) mode_q <= bus_wdata & MASK_MODE;
      if (wr_ctrl) ctrl_q <= bus_wdata & MASK_CTRL;
      if (wr_port) port_q <= bus_wdata & MASK_PORT;
      if (wr_fctl) trig_code_q <= bus_wdata[7:6];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tend_q   <= 1'b1;
      tde_q    <= 1'b1;
      brk_q    <= 1'b0;
      rdf_q    <= 1'b0;
      irq_rx_q <= 1'b0;
      irq_tx_q <= 1'b0;
    end else begin
      if (wr_ctrl && !bus_wdata[CB_TXEN])       tend_q <= 1'b1;
      else if (rd_stat && ctrl_q[CB_TXEN])      tend_q <= 1'b1;
      else if (wr_stat && !bus_wdata[FB_TEND])  tend_q <= 1'b0;

      if (wr_txd)                               tde_q <= 1'b0;
      else if (rd_stat && ctrl_q[CB_TXEN])      tde_q <= 1'b1;
      else if (wr_stat && !bus_wdata[FB_TDE])   tde_q <= 1'b0;

      if (rx_break)                             brk_q <= 1'b1;
      else if (wr_stat && !bus_wdata[FB_BRK])   brk_q <= 1'b0;

      if (reach_trig)                           rdf_q <= 1'b1;
      else if (drop_trig)                       rdf_q <= 1'b0;
      else if (wr_stat && !bus_wdata[FB_RDF])   rdf_q <= 1'b0;

      if (reach_trig && ctrl_q[CB_RXIE])        irq_rx_q <= 1'b1;
      else if (wr_ctrl && !bus_wdata[CB_RXIE])  irq_rx_q <= 1'b0;
      else if (wr_stat && (!bus_wdata[FB_RDF] || !bus_wdata[FB_DR]))
                                                irq_rx_q <= 1'b0;

      if (wr_ctrl) irq_tx_q <= bus_wdata[CB_TXIE];
    end
  end

  assign irq_rx = irq_rx_q;
  assign irq_tx = irq_tx_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        AW'(OFS_MODE): bus_rdata = mode_q;
        AW'(OFS_CTRL): bus_rdata = ctrl_q;
        AW'(OFS_STAT): begin
          bus_rdata[FB_TEND] = tend_q;
          bus_rdata[FB_TDE]  = tde_q;
          bus_rdata[FB_BRK]  = brk_q;
          bus_rdata[FB_RDF]  = rdf_q;
        end
        AW'(OFS_RXD):  bus_rdata = (fifo_cnt != '0) ? fifo_head : '0;
        AW'(OFS_FCTL): bus_rdata = {trig_code_q, 6'b0};
        AW'(OFS_RCNT): bus_rdata = DW'(fifo_cnt);
        AW'(OFS_PORT): bus_rdata = port_q;
        default:       bus_rdata = '0;
      endcase
    end
  end

  assert_rx_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !bus_rd && !bus_wr) |=> $stable(fifo_cnt));

  assert_rdf_reach_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_push_ok && !fifo_pop_ok && !bus_wr) |=> (fifo_cnt < trig_lvl) || rdf_q);

  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_rx) |-> $past(ctrl_q[CB_RXIE]));

  assert_tx_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (irq_tx == $past(bus_wdata[CB_TXIE])));

  assert_tend_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !bus_wdata[CB_TXEN]) |=> tend_q);

  assert_break_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_break |=> brk_q);
endmodule

// File: tb/sfr_serial_core_tb_top.sv
module sfr_serial_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_ready;
  logic       rx_break = 1'b0;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       tx_ready = 1'b0;
  logic       irq_rx, irq_tx;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] rv;

  always #5 clk = ~clk;

  sfr_serial_core dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .rx_break(rx_break), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // One bus/stream cycle; any mix of write, read, receive transfer and break.
  task automatic cyc(input bit wr, input bit rd, input logic [7:0] a,
                     input logic [7:0] wd, input bit push, input logic [7:0] pd,
                     input bit brk, output logic [7:0] rdata);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
    rx_valid = push; rx_data = pd; rx_break = brk;
    #2 rdata = bus_rdata;
    @(posedge clk);
    #1;
    bus_wr = 0; bus_rd = 0; rx_valid = 0; rx_break = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] x;
    cyc(1, 0, a, d, 0, 0, 0, x);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    cyc(0, 1, a, 0, 0, 0, 0, d);
  endtask

  task automatic push(input logic [7:0] d);
    logic [7:0] x;
    cyc(0, 0, 0, 0, 1, d, 0, x);
  endtask

  initial begin
    int cyc_cnt = 0;
    while (!done) begin
      @(posedge clk);
      cyc_cnt++;
      if (cyc_cnt > 100000) begin
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<=100000", cyc_cnt);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    check("R1 irq_rx", irq_rx, 0);
    check("R1 irq_tx", irq_tx, 0);
    check("R1 tx_valid", tx_valid, 0);
    check("R1 rx_ready", rx_ready, 0);
    rd(8'h08, rv); check("R1 ctrl", rv, 8'h20);
    rd(8'h10, rv); check("R1 status", rv, 8'h60);
    rd(8'h1C, rv); check("R1 count", rv, 0);

    // R2 masks and unmapped reads
    wr(8'h00, 8'hFF); rd(8'h00, rv); check("R2 mode", rv, 8'h7B);
    wr(8'h20, 8'hFF); rd(8'h20, rv); check("R2 port", rv, 8'hF3);
    rd(8'h04, rv); check("R2 unmapped", rv, 0);
    rd(8'h40, rv); check("R2 unmapped hi", rv, 0);
    wr(8'h08, 8'hFF); rd(8'h08, rv); check("R2 ctrl", rv, 8'hFA);
    check("R8 irq_tx set", irq_tx, 1);

    // R4 receive gating
    wr(8'h08, 8'h20);
    check("R8 irq_tx clear", irq_tx, 0);
    check("R4 rx_ready off", rx_ready, 0);
    push(8'h11);
    rd(8'h1C, rv); check("R4 ignored push", rv, 0);
    wr(8'h08, 8'h70);
    check("R4 rx_ready on", rx_ready, 1);

    // R3/R5/R6/R7 sweep over every trigger code
    for (int code = 0; code < 4; code++) begin
      int lvl;
      lvl = (code == 0) ? 1 : (code == 1) ? 4 : (code == 2) ? 8 : 14;
      wr(8'h18, 8'((code << 6) | 2));
      wr(8'h10, 8'h7D);
      check("R7 irq cleared by status", irq_rx, 0);
      rd(8'h18, rv); check("R2 fctl readback", rv, code << 6);
      for (int n = 1; n <= 16; n++) begin
        push(8'(code * 16 + n));
        rd(8'h10, rv);
        check("R5 rdf on push", rv[1], (n >= lvl) ? 1 : 0);
        check("R7 irq on push", irq_rx, (n >= lvl) ? 1 : 0);
      end
      push(8'hEE);
      rd(8'h1C, rv); check("R3 full count", rv, 16);
      for (int k = 1; k <= 16; k++) begin
        rd(8'h14, rv); check("R3 order", rv, code * 16 + k);
        rd(8'h10, rv);
        check("R6 rdf on pop", rv[1], ((16 - k) >= lvl) ? 1 : 0);
      end
      check("R7 irq kept by pop", irq_rx, 1);
      rd(8'h14, rv); check("R6 empty read", rv, 0);
      rd(8'h1C, rv); check("R6 empty count", rv, 0);
    end

    // R14 push and status clear in the same cycle (trigger 1)
    wr(8'h18, 8'h02);
    wr(8'h10, 8'h7D);
    check("R7 irq clear", irq_rx, 0);
    cyc(1, 0, 8'h10, 8'h7D, 1, 8'hA1, 0, rv);
    rd(8'h10, rv); check("R14 rdf wins", rv[1], 1);
    check("R14 irq wins", irq_rx, 1);

    // R6 read and transfer in the same cycle
    cyc(0, 1, 8'h14, 0, 1, 8'hA2, 0, rv);
    check("R6 simultaneous data", rv, 8'hA1);
    rd(8'h1C, rv); check("R6 simultaneous count", rv, 1);
    rd(8'h14, rv); check("R6 next data", rv, 8'hA2);

    // R13 flush with a transfer in the same cycle
    push(8'hB1); push(8'hB2);
    cyc(1, 0, 8'h18, 8'h02, 1, 8'hB3, 0, rv);
    rd(8'h1C, rv); check("R13 flush count", rv, 0);
    rd(8'h14, rv); check("R13 flush data", rv, 0);

    // R7 interrupt clear paths
    push(8'hC1);
    check("R7 irq up", irq_rx, 1);
    wr(8'h08, 8'h30);
    check("R7 ctrl clear", irq_rx, 0);
    wr(8'h08, 8'h70);
    push(8'hC2);
    check("R7 irq up again", irq_rx, 1);
    wr(8'h10, 8'h7E);
    check("R7 dr-bit clear", irq_rx, 0);
    rd(8'h10, rv); check("R10 rdf kept by one", rv[1], 1);

    // R10/R11/R12 status behaviour
    wr(8'h10, 8'h00);
    rd(8'h10, rv); check("R10 all cleared", rv, 8'h00);
    rd(8'h10, rv); check("R11 rearm on read", rv, 8'h60);
    cyc(0, 0, 0, 0, 0, 0, 1, rv);
    rd(8'h10, rv); check("R12 break", rv, 8'h70);
    wr(8'h10, 8'h6F);
    rd(8'h10, rv); check("R10 break cleared", rv, 8'h60);
    wr(8'h10, 8'hFF);
    rd(8'h10, rv); check("R10 ones no effect", rv, 8'h60);
    wr(8'h08, 8'h50);
    wr(8'h10, 8'h00);
    rd(8'h10, rv); check("R11 cleared no txen", rv, 8'h00);
    wr(8'h08, 8'h50);
    rd(8'h10, rv); check("R11 tend on ctrl", rv, 8'h40);
    rd(8'h10, rv); check("R11 no rearm", rv, 8'h40);

    // R9 transmit holding
    wr(8'h08, 8'h70);
    wr(8'h0C, 8'h5A);
    check("R9 tx_valid", tx_valid, 1);
    check("R9 tx_data", tx_data, 8'h5A);
    rd(8'h10, rv); check("R9 tde cleared", rv, 8'h40);
    wr(8'h0C, 8'h33);
    check("R9 pending kept", tx_data, 8'h5A);
    @(negedge clk) tx_ready = 1'b1;
    @(posedge clk) #1 tx_ready = 1'b0;
    check("R9 taken", tx_valid, 0);
    wr(8'h0C, 8'h77);
    check("R9 reload", tx_data, 8'h77);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule